// File: doc/BRIEF.md
# Interrupt Mask and Priority Register File with Enable Event Generation

This block holds a small bank of interrupt control registers. Some are mask registers made of one-bit fields, the rest are priority registers made of wider fields. Each mask register answers at two addresses: writing the first sets bits and writing the second clears them. A priority register answers either at such a set/clear pair or at a single address that takes the written value as it is. Reads return the stored value whichever of its addresses is used.

Each accepted write is compared with the old value one field at a time. Every field that changed produces an enable event (the field is now nonzero) or a disable event (the field is now zero) for the interrupt source tied to that field. A source that stands for a group and has no vector of its own passes the event along a linked chain of member sources. Events leave the block one walk step per clock while `busy` is high. The pending and vector logic downstream counts these events per source.

Top module: `irq_maskprio_regs`

## Requirements
- R1: Only address bits 28..0 take part in decoding. Bits 31..29 are ignored, and an address that differs in bit 28 or below matches no register.
- R2: For a register with a set/clear pair, a write to the set address (base) stores old OR data. A write to the clear address (base + 4) stores old AND NOT data.
- R3: A priority register that has only one address stores the written data directly. Base + 4 of that register is not decoded.
- R4: Mask fields are 1 bit and priority fields are PRIO_FW (4) bits wide. Fields are processed from the most significant one down, and field k in that order belongs to the k-th entry of the register's source list.
- R5: A field with unchanged contents produces no event. A changed field that is now nonzero produces an event with `ev_enable`=1, and one that is now zero produces an event with `ev_enable`=0.
- R6: No event is issued for source id 0. No event is issued for a reserved source, meaning a source with no successor that either lacks a vector or has no enable slot.
- R7: A source reached from a field that has no vector issues no event itself. The walk follows its successor chain, and every member with a vector gets the same polarity. A source with a vector that is reached directly from a field does not follow its chain.
- R8: A read of either address of a register puts its stored value on `bus_rdata` on the clock edge that samples the read. `bus_rdata` holds between reads.
- R9: A write to an address that matches no register changes nothing and starts no events. A read from such an address returns 0.
- R10: `busy` rises in the cycle after a write that changes at least one field. Each cycle of `busy` handles one walk step: one changed field or one chain member. Walk steps follow field order and chain order. `ev_valid` is high only while `busy` is high.
- R11: A write presented while `busy` is high is dropped and produces no events.
- R12: After reset all registers read 0, and `busy` and `ev_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (32) | Access address |
| bus_wdata | input | REG_W (8) | Write data |
| bus_rdata | output | REG_W (8) | Registered read data |
| busy | output | 1 | Event walk in progress |
| ev_valid | output | 1 | Enable/disable event strobe |
| ev_id | output | SRC_W (5) | Target source id of the event |
| ev_enable | output | 1 | 1 = enable, 0 = disable |

## Verification
The edge that samples a write also stores the new value. The first walk step appears in the cycle after that edge, and each later step takes one more cycle. The bench therefore samples `busy` at the falling edge right after the write and then counts falling edges until `busy` drops. It checks that count against the number of steps its own model of the walk predicts. Events are collected at falling edges and compared in order with the model's list. Read data is due on the capture edge of the read, so it is checked at the next falling edge.

// File: rtl/imp_pkg.sv
package imp_pkg;

    // Number of low address bits that take part in decoding
    localparam int CMP_W = 29;

    typedef enum logic [1:0] {
        WOP_DIRECT,
        WOP_SET,
        WOP_CLEAR
    } wop_e;

    typedef enum logic {
        WK_IDLE,
        WK_NODE
    } walk_e;

    // Sizes of the default configuration
    localparam int DFLT_NREG  = 4;
    localparam int DFLT_REG_W = 8;
    localparam int DFLT_NSRC  = 32;
    localparam int DFLT_SRC_W = 5;

    // Field-to-source map: entry (r*REG_W + k) holds the source of field k of register r
    function automatic logic [DFLT_NREG*DFLT_REG_W*DFLT_SRC_W-1:0] dflt_field_src();
        logic [DFLT_NREG*DFLT_REG_W*DFLT_SRC_W-1:0] m;
        m = '0;
        for (int k = 0; k < DFLT_REG_W; k++) begin
            m[(0*DFLT_REG_W + k)*DFLT_SRC_W +: DFLT_SRC_W] = (k == 7) ? 5'd0 : 5'(k + 1);
            m[(1*DFLT_REG_W + k)*DFLT_SRC_W +: DFLT_SRC_W] = 5'(k + 8);
        end
        m[(2*DFLT_REG_W + 0)*DFLT_SRC_W +: DFLT_SRC_W] = 5'd20;
        m[(2*DFLT_REG_W + 1)*DFLT_SRC_W +: DFLT_SRC_W] = 5'd24;
        m[(3*DFLT_REG_W + 0)*DFLT_SRC_W +: DFLT_SRC_W] = 5'd26;
        m[(3*DFLT_REG_W + 1)*DFLT_SRC_W +: DFLT_SRC_W] = 5'd28;
        return m;
    endfunction

    function automatic logic [DFLT_NSRC-1:0] dflt_src_vect();
        logic [DFLT_NSRC-1:0] v;
        v = '0;
        for (int i = 1; i < 16; i++) v[i] = 1'b1;
        v[21] = 1'b1; v[22] = 1'b1; v[26] = 1'b1; v[27] = 1'b1; v[28] = 1'b1;
        return v;
    endfunction

    function automatic logic [DFLT_NSRC-1:0] dflt_src_en();
        logic [DFLT_NSRC-1:0] v;
        v = '0;
        for (int i = 1; i < 16; i++) v[i] = 1'b1;
        v[20] = 1'b1; v[21] = 1'b1; v[22] = 1'b1; v[26] = 1'b1; v[27] = 1'b1;
        return v;
    endfunction

    function automatic logic [DFLT_NSRC*DFLT_SRC_W-1:0] dflt_src_next();
        logic [DFLT_NSRC*DFLT_SRC_W-1:0] n;
        n = '0;
        n[20*DFLT_SRC_W +: DFLT_SRC_W] = 5'd21;
        n[21*DFLT_SRC_W +: DFLT_SRC_W] = 5'd22;
        n[26*DFLT_SRC_W +: DFLT_SRC_W] = 5'd27;
        return n;
    endfunction

endpackage

// File: rtl/imp_decode.sv
module imp_decode
    import imp_pkg::*;
#(
    parameter int                 N_REG      = 4,
    parameter int                 RIDX_W     = 2,
    parameter int                 N_MASK     = 2,
    parameter int                 ADDR_W     = 32,
    parameter logic [ADDR_W-1:0]  MASK_BASE  = 32'h0000_0100,
    parameter logic [ADDR_W-1:0]  PRIO_BASE  = 32'h0000_0200,
    parameter int                 REG_STRIDE = 16,
    parameter int                 CLR_OFS    = 4,
    parameter logic [N_REG-1:0]   REG_DUAL   = '1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [RIDX_W-1:0] reg_idx,
    output wop_e              op
);

    logic [N_REG-1:0] hit_set;
    logic [N_REG-1:0] hit_clr;
    logic             unused_addr_hi;

    assign unused_addr_hi = ^addr[ADDR_W-1:CMP_W];

    for (genvar r = 0; r < N_REG; r++) begin : g_reg
        localparam bit                IS_PRIO = (r >= N_MASK);
        localparam int                IDX     = IS_PRIO ? r - N_MASK : r;
        localparam logic [ADDR_W-1:0] BASE    = IS_PRIO ? PRIO_BASE : MASK_BASE;
        localparam logic [ADDR_W-1:0] SET_A   = BASE + ADDR_W'(IDX * REG_STRIDE);
        localparam logic [ADDR_W-1:0] CLR_A   = SET_A + ADDR_W'(CLR_OFS);

        assign hit_set[r] = (addr[CMP_W-1:0] == SET_A[CMP_W-1:0]);
        assign hit_clr[r] = REG_DUAL[r] && (addr[CMP_W-1:0] == CLR_A[CMP_W-1:0]);
    end

    always_comb begin
        hit     = 1'b0;
        reg_idx = '0;
        op      = WOP_DIRECT;
        for (int r = N_REG - 1; r >= 0; r--) begin
            if (hit_set[r] || hit_clr[r]) begin
                hit     = 1'b1;
                reg_idx = RIDX_W'(r);
                if (hit_clr[r])       op = WOP_CLEAR;
                else if (REG_DUAL[r]) op = WOP_SET;
                else                  op = WOP_DIRECT;
            end
        end
    end

endmodule

// File: rtl/imp_bank.sv
module imp_bank
    import imp_pkg::*;
#(
    parameter int N_REG   = 4,
    parameter int RIDX_W  = 2,
    parameter int N_MASK  = 2,
    parameter int REG_W   = 8,
    parameter int PRIO_FW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_go,
    input  logic              rd_go,
    input  logic              hit,
    input  logic [RIDX_W-1:0] reg_idx,
    input  wop_e              op,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic [REG_W-1:0]  chg,
    output logic [REG_W-1:0]  nz
);

    localparam int PNF = REG_W / PRIO_FW;

    logic [REG_W-1:0] val_q [N_REG];
    logic [REG_W-1:0] old_v;
    logic [REG_W-1:0] new_v;
    logic [REG_W-1:0] mchg, mnz, pchg, pnz;
    logic             is_prio;

    assign old_v   = hit ? val_q[reg_idx] : '0;
    assign is_prio = (int'(reg_idx) >= N_MASK);

    always_comb begin
        unique case (op)
            WOP_SET:   new_v = old_v | wdata;
            WOP_CLEAR: new_v = old_v & ~wdata;
            default:   new_v = wdata;
        endcase
    end

    // Field k in walk order is counted from the most significant end
    for (genvar k = 0; k < REG_W; k++) begin : g_mfield
        assign mchg[k] = old_v[REG_W-1-k] ^ new_v[REG_W-1-k];
        assign mnz[k]  = new_v[REG_W-1-k];
    end

    for (genvar k = 0; k < REG_W; k++) begin : g_pfield
        if (k < PNF) begin : g_used
            assign pchg[k] = old_v[(PNF-1-k)*PRIO_FW +: PRIO_FW] != new_v[(PNF-1-k)*PRIO_FW +: PRIO_FW];
            assign pnz[k]  = |new_v[(PNF-1-k)*PRIO_FW +: PRIO_FW];
        end else begin : g_pad
            assign pchg[k] = 1'b0;
            assign pnz[k]  = 1'b0;
        end
    end

    assign chg = is_prio ? pchg : mchg;
    assign nz  = is_prio ? pnz  : mnz;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < N_REG; r++) val_q[r] <= '0;
            rdata <= '0;
        end else begin
            if (wr_go) val_q[reg_idx] <= new_v;
            if (rd_go) rdata <= hit ? val_q[reg_idx] : '0;
        end
    end

endmodule

// File: rtl/imp_walk.sv
module imp_walk
    import imp_pkg::*;
#(
    parameter int                           N_REG     = 4,
    parameter int                           RIDX_W    = 2,
    parameter int                           REG_W     = 8,
    parameter int                           N_SRC     = 32,
    parameter int                           SRC_W     = 5,
    parameter logic [N_REG*REG_W*SRC_W-1:0] FIELD_SRC = '0,
    parameter logic [N_SRC-1:0]             SRC_VECT  = '0,
    parameter logic [N_SRC-1:0]             SRC_EN    = '0,
    parameter logic [N_SRC*SRC_W-1:0]       SRC_NEXT  = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [RIDX_W-1:0] reg_idx,
    input  logic [REG_W-1:0]  chg,
    input  logic [REG_W-1:0]  nz,
    output logic              busy,
    output logic              ev_valid,
    output logic [SRC_W-1:0]  ev_id,
    output logic              ev_enable
);

    walk_e             st_q;
    logic [REG_W-1:0]  pend_q, nz_q;
    logic [RIDX_W-1:0] reg_q;
    logic [SRC_W-1:0]  cur_q;
    logic              grp_q, en_q;

    logic              cur_vect, reserved, live, follow, advance, fany;
    logic [SRC_W-1:0]  cur_next, field_id;
    logic [REG_W-1:0]  src_pend, src_nz;
    logic [RIDX_W-1:0] src_reg;
    int                fidx;

    assign cur_vect = SRC_VECT[cur_q];
    assign cur_next = SRC_NEXT[int'(cur_q)*SRC_W +: SRC_W];
    assign reserved = (cur_next == '0) && (!cur_vect || !SRC_EN[cur_q]);
    assign live     = (st_q == WK_NODE) && (cur_q != '0) && !reserved;
    assign follow   = live && (grp_q || !cur_vect) && (cur_next != '0);
    assign advance  = (st_q == WK_IDLE) ? start : !follow;

    assign src_pend = (st_q == WK_IDLE) ? chg : pend_q;
    assign src_nz   = (st_q == WK_IDLE) ? nz : nz_q;
    assign src_reg  = (st_q == WK_IDLE) ? reg_idx : reg_q;

    // Lowest index = most significant field comes first
    always_comb begin
        fany = 1'b0;
        fidx = 0;
        for (int k = REG_W - 1; k >= 0; k--) begin
            if (src_pend[k]) begin
                fany = 1'b1;
                fidx = k;
            end
        end
    end

    assign field_id = FIELD_SRC[(int'(src_reg)*REG_W + fidx)*SRC_W +: SRC_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= WK_IDLE;
            pend_q <= '0;
            nz_q   <= '0;
            reg_q  <= '0;
            cur_q  <= '0;
            grp_q  <= 1'b0;
            en_q   <= 1'b0;
        end else if (advance) begin
            if (fany) begin
                st_q   <= WK_NODE;
                cur_q  <= field_id;
                grp_q  <= 1'b0;
                en_q   <= src_nz[fidx];
                pend_q <= src_pend & ~(REG_W'(1) << fidx);
                nz_q   <= src_nz;
                reg_q  <= src_reg;
            end else begin
                st_q <= WK_IDLE;
            end
        end else if (follow) begin
            cur_q <= cur_next;
            grp_q <= 1'b1;
        end
    end

    assign busy      = (st_q == WK_NODE);
    assign ev_valid  = live && cur_vect;
    assign ev_id     = cur_q;
    assign ev_enable = en_q;

endmodule

// File: rtl/irq_maskprio_regs.sv
module irq_maskprio_regs
    import imp_pkg::*;
#(
    parameter int                                  N_MASK     = 2,
    parameter int                                  N_PRIO     = 2,
    parameter int                                  REG_W      = 8,
    parameter int                                  PRIO_FW    = 4,
    parameter int                                  N_SRC      = 32,
    parameter int                                  SRC_W      = 5,
    parameter int                                  ADDR_W     = 32,
    parameter logic [ADDR_W-1:0]                   MASK_BASE  = 32'h0000_0100,
    parameter logic [ADDR_W-1:0]                   PRIO_BASE  = 32'h0000_0200,
    parameter int                                  REG_STRIDE = 16,
    parameter int                                  CLR_OFS    = 4,
    parameter logic [N_PRIO-1:0]                   PRIO_DUAL  = 2'b01,
    parameter logic [(N_MASK+N_PRIO)*REG_W*SRC_W-1:0] FIELD_SRC = dflt_field_src(),
    parameter logic [N_SRC-1:0]                    SRC_VECT   = dflt_src_vect(),
    parameter logic [N_SRC-1:0]                    SRC_EN     = dflt_src_en(),
    parameter logic [N_SRC*SRC_W-1:0]              SRC_NEXT   = dflt_src_next()
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              busy,
    output logic              ev_valid,
    output logic [SRC_W-1:0]  ev_id,
    output logic              ev_enable
);

    localparam int               N_REG    = N_MASK + N_PRIO;
    localparam int               RIDX_W   = (N_REG > 1) ? $clog2(N_REG) : 1;
    localparam logic [N_REG-1:0] REG_DUAL = {PRIO_DUAL, {N_MASK{1'b1}}};

    logic              hit, wr_go, rd_go;
    logic [RIDX_W-1:0] reg_idx;
    wop_e              op;
    logic [REG_W-1:0]  chg, nz;

    assign wr_go = bus_valid && bus_we && hit && !busy;
    assign rd_go = bus_valid && !bus_we;

    imp_decode #(
        .N_REG(N_REG), .RIDX_W(RIDX_W), .N_MASK(N_MASK), .ADDR_W(ADDR_W),
        .MASK_BASE(MASK_BASE), .PRIO_BASE(PRIO_BASE), .REG_STRIDE(REG_STRIDE),
        .CLR_OFS(CLR_OFS), .REG_DUAL(REG_DUAL)
    ) u_dec (
        .addr(bus_addr), .hit(hit), .reg_idx(reg_idx), .op(op)
    );

    imp_bank #(
        .N_REG(N_REG), .RIDX_W(RIDX_W), .N_MASK(N_MASK), .REG_W(REG_W), .PRIO_FW(PRIO_FW)
    ) u_bank (
        .clk(clk), .rst(rst), .wr_go(wr_go), .rd_go(rd_go), .hit(hit),
        .reg_idx(reg_idx), .op(op), .wdata(bus_wdata), .rdata(bus_rdata),
        .chg(chg), .nz(nz)
    );

    imp_walk #(
        .N_REG(N_REG), .RIDX_W(RIDX_W), .REG_W(REG_W), .N_SRC(N_SRC), .SRC_W(SRC_W),
        .FIELD_SRC(FIELD_SRC), .SRC_VECT(SRC_VECT), .SRC_EN(SRC_EN), .SRC_NEXT(SRC_NEXT)
    ) u_walk (
        .clk(clk), .rst(rst), .start(wr_go), .reg_idx(reg_idx), .chg(chg), .nz(nz),
        .busy(busy), .ev_valid(ev_valid), .ev_id(ev_id), .ev_enable(ev_enable)
    );

endmodule

// File: rtl/imp_checker.sv
module imp_checker #(
    parameter int               N_SRC    = 32,
    parameter int               SRC_W    = 5,
    parameter int               REG_W    = 8,
    parameter logic [N_SRC-1:0] SRC_VECT = '0
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_valid,
    input logic             bus_we,
    input logic [REG_W-1:0] bus_rdata,
    input logic             busy,
    input logic             ev_valid,
    input logic [SRC_W-1:0] ev_id
);

    assert_ev_inside_busy_R10: assert property (@(posedge clk) disable iff (rst)
        ev_valid |-> busy);

    assert_busy_from_write_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(bus_valid && bus_we));

    assert_quiet_after_reset_R12: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !ev_valid && bus_rdata == '0));

    assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_valid && !bus_we) |-> $stable(bus_rdata));

    assert_ev_target_live_R6: assert property (@(posedge clk) disable iff (rst)
        ev_valid |-> (ev_id != '0 && SRC_VECT[ev_id]));

endmodule

bind irq_maskprio_regs imp_checker #(
    .N_SRC(N_SRC), .SRC_W(SRC_W), .REG_W(REG_W), .SRC_VECT(SRC_VECT)
) u_chk (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .busy(busy), .ev_valid(ev_valid), .ev_id(ev_id)
);

// File: tb/tb_irq_maskprio_regs.sv
module tb_irq_maskprio_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        busy, ev_valid, ev_enable;
    logic [4:0]  ev_id;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int mdl [4];
    int evq [$];
    int expq [$];

    always #10 clk = ~clk;

    irq_maskprio_regs dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy), .ev_valid(ev_valid), .ev_id(ev_id), .ev_enable(ev_enable)
    );

    always @(negedge clk) if (!rst && ev_valid) evq.push_back(int'(ev_id) * 2 + int'(ev_enable));

    always @(posedge clk) begin
        cyc++;
        if (cyc > 180000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Configuration as stated in the requirements
    function automatic int fsrc(input int r, input int k);
        case (r)
            0: return (k == 7) ? 0 : k + 1;
            1: return k + 8;
            2: return (k == 0) ? 20 : 24;
            default: return (k == 0) ? 26 : 28;
        endcase
    endfunction
    function automatic bit has_vect(input int id);
        return (id >= 1 && id <= 15) || id == 21 || id == 22 || id == 26 || id == 27 || id == 28;
    endfunction
    function automatic bit has_en(input int id);
        return (id >= 1 && id <= 15) || id == 20 || id == 21 || id == 22 || id == 26 || id == 27;
    endfunction
    function automatic int nxt(input int id);
        case (id)
            20: return 21;
            21: return 22;
            26: return 27;
            default: return 0;
        endcase
    endfunction
    function automatic logic [31:0] base_addr(input int r);
        return (r < 2) ? 32'(32'h100 + r * 16) : 32'(32'h200 + (r - 2) * 16);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected walk: fills expq, returns number of walk steps
    task automatic model(input int r, input int oldv, input int newv, output int steps);
        int fw, nf, mk;
        fw = (r < 2) ? 1 : 4;
        nf = 8 / fw;
        mk = (1 << fw) - 1;
        steps = 0;
        expq.delete();
        for (int k = 0; k < nf; k++) begin
            int o, n, id, g, e;
            o = (oldv >> ((nf - 1 - k) * fw)) & mk;
            n = (newv >> ((nf - 1 - k) * fw)) & mk;
            if (o != n) begin
                e = (n != 0) ? 1 : 0;
                id = fsrc(r, k);
                g = 0;
                forever begin
                    steps++;
                    if (id == 0) break;
                    if (nxt(id) == 0 && (!has_vect(id) || !has_en(id))) break;
                    if (has_vect(id)) expq.push_back(id * 2 + e);
                    if ((g == 1 || !has_vect(id)) && nxt(id) != 0) begin
                        id = nxt(id);
                        g = 1;
                    end else break;
                end
            end
        end
    endtask

    // op: 0 direct, 1 set, 2 clear
    task automatic write_chk(input int r, input int op, input int data, input bit hi, input string req);
        logic [31:0] addr;
        int oldv, newv, steps, n;
        addr = base_addr(r) + ((op == 2) ? 32'd4 : 32'd0);
        if (hi) addr = addr | 32'hA000_0000;
        oldv = mdl[r];
        newv = (op == 1) ? ((oldv | data) & 255) : (op == 2) ? (oldv & ~data & 255) : (data & 255);
        model(r, oldv, newv, steps);
        @(negedge clk);
        evq.delete();
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = addr; bus_wdata = 8'(data);
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
        chk(busy == (steps > 0), "R10 busy start", int'(busy), int'(steps > 0));
        n = 0;
        while (busy && n < 200) begin
            n++;
            @(negedge clk);
        end
        #1;
        chk(n == steps, "R10 step count", n, steps);
        chk(evq.size() == expq.size(), {req, " event count"}, evq.size(), expq.size());
        for (int i = 0; i < expq.size() && i < evq.size(); i++)
            chk(evq[i] == expq[i], {req, " event id*2+en"}, evq[i], expq[i]);
        mdl[r] = newv;
    endtask

    task automatic read_chk(input logic [31:0] addr, input int exp, input string req);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b0; bus_addr = addr;
        @(negedge clk);
        bus_valid = 1'b0;
        chk(int'(bus_rdata) == exp, req, int'(bus_rdata), exp);
    endtask

    task automatic write_ignored(input logic [31:0] addr, input int data, input string req);
        @(negedge clk);
        evq.delete();
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = addr; bus_wdata = 8'(data);
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
        chk(busy == 1'b0, {req, " no busy"}, int'(busy), 0);
        @(negedge clk);
        chk(evq.size() == 0, {req, " no events"}, evq.size(), 0);
    endtask

    initial begin
        int steps;
        for (int r = 0; r < 4; r++) mdl[r] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        chk(busy == 1'b0, "R12 busy", int'(busy), 0);
        chk(ev_valid == 1'b0, "R12 ev_valid", int'(ev_valid), 0);
        for (int r = 0; r < 4; r++) read_chk(base_addr(r), 0, "R12 reset value");

        // R2 R4 R5 R6: mask registers, set and clear aliases
        for (int r = 0; r < 2; r++) begin
            for (int v = 0; v < 256; v++) begin
                write_chk(r, 1, v, (v % 3 == 0), "R2/R4/R5/R6 mask set");
                write_chk(r, 2, (v * 7 + 1) & 255, (v % 5 == 0), "R2/R4/R5/R6 mask clear");
                if (v % 16 == 0) begin
                    read_chk(base_addr(r), mdl[r], "R8 read set alias");
                    read_chk(base_addr(r) + 32'd4, mdl[r], "R8 read clear alias");
                end
            end
        end

        // R7: dual priority register whose high field drives a group chain
        for (int v = 0; v < 256; v++) begin
            write_chk(2, 1, v, (v % 2 == 0), "R7/R4 prio set");
            write_chk(2, 2, (v * 5 + 3) & 255, 1'b0, "R7/R4 prio clear");
            if (v % 32 == 0) read_chk(base_addr(2) + 32'd4, mdl[2], "R8 prio clear alias");
        end

        // R3: single-address priority register, direct writes
        for (int v = 0; v < 256; v++) begin
            write_chk(3, 0, v ^ 8'h3C, (v % 4 == 1), "R3/R6/R7 prio direct");
            if (v % 32 == 0) read_chk(base_addr(3), mdl[3], "R3 direct readback");
        end
        write_ignored(base_addr(3) + 32'd4, 8'hFF, "R3 no clear alias");
        read_chk(base_addr(3), mdl[3], "R3 value kept");
        read_chk(base_addr(3) + 32'd4, 0, "R3 clear alias reads zero");

        // R9: unmapped address
        write_ignored(32'h0000_0300, 8'hFF, "R9 unmapped write");
        read_chk(32'h0000_0300, 0, "R9 unmapped read");
        for (int r = 0; r < 4; r++) read_chk(base_addr(r), mdl[r], "R9 registers unchanged");

        // R1: bits above 28 ignored, bit 28 decoded
        read_chk(32'hE000_0200, mdl[2], "R1 high alias read");
        write_ignored(32'h1000_0100, 8'hFF, "R1 bit28 write");
        read_chk(base_addr(0), mdl[0], "R1 bit28 left reg0");
        read_chk(32'h1000_0100, 0, "R1 bit28 read");

        // R11: write during busy is dropped
        write_chk(2, 0, 8'hFF, 1'b0, "R11 prep");
        write_chk(2, 2, 8'hFF, 1'b0, "R11 prep clear");
        model(2, 0, 8'hF0, steps);
        @(negedge clk);
        evq.delete();
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = base_addr(2); bus_wdata = 8'hF0;
        @(negedge clk);
        chk(busy == 1'b1, "R11 busy", int'(busy), 1);
        bus_addr = base_addr(1); bus_wdata = 8'h55;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
        for (int i = 0; i < 10 && busy; i++) @(negedge clk);
        #1;
        chk(evq.size() == expq.size(), "R11 events of first write only", evq.size(), expq.size());
        mdl[2] = 8'hF0;
        read_chk(base_addr(1), mdl[1], "R11 dropped write");
        read_chk(base_addr(2), mdl[2], "R11 first write kept");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule